// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides, for every identifier that the CAN receiver hands over, whether the frame is wanted and which of fifteen message slots takes it. The host fills in each slot with an identifier, a format bit (standard 11-bit or extended 29-bit), a direction bit and an enable bit. It also loads three masks: one shared mask for standard identifiers, one for extended identifiers, and an extra mask that only slot 15 applies.

Slots 1 to 14 compare the incoming identifier with their own identifier through the shared mask of the frame's format. Slot 15 only receives. It applies the shared mask and its own extra mask together, so a single slot can collect a whole group of identifiers. It acts as a catch-all that is used only when none of the lower slots claims the frame. The result is registered and appears one clock after the identifier strobe.

Top module: `canAcceptFilter`

## Requirements
- R1: After reset, every slot is disabled and all three masks are all ones, so no frame produces a hit until slots are configured.
- R2: A frame strobed on `frmValid` in cycle n gives `hitValid` high for exactly cycle n+1 if some slot accepts it. `hitValid` is never high in a cycle that does not follow a strobe.
- R3: For a standard frame, only identifier bits [10:0] are compared, through the standard mask. A mask bit of 1 means the bit must be equal, and a 0 means the bit is ignored.
- R4: For an extended frame, all 29 identifier bits are compared through the extended mask, using the same mask polarity as R3.
- R5: A slot takes part only when it is enabled, set to receive (direction bit 1), and its format bit (1 = extended) equals the frame's format.
- R6: When several of slots 1 to 14 accept a frame, the lowest-numbered one is reported.
- R7: Slot 15 is reported only when none of slots 1 to 14 accepts the frame. For slot 15, an identifier bit must match only where both the shared mask of the frame's format and the slot-15 mask hold a 1.
- R8: Slot 15 always receives. The direction bit written to it has no effect.
- R9: Remote frames are filtered exactly like data frames. `hitRemote` carries the frame's remote flag together with a hit and is 0 otherwise.
- R10: A configuration write in the same cycle as a frame strobe takes effect only for later frames. The current frame sees the old settings.
- R11: `hitIdx` gives the slot number 1 to 15 while `hitValid` is high, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Host configuration write strobe |
| cfgTarget | input | 2 | Write target: 0 slot, 1 standard mask, 2 extended mask, 3 slot-15 mask |
| cfgObj | input | 4 | Slot number 1..15 for slot writes; other values are ignored |
| cfgId | input | 29 | Identifier or mask value; standard mask uses bits [10:0] |
| cfgValid | input | 1 | Slot enable bit |
| cfgRx | input | 1 | Slot direction bit, 1 = receive |
| cfgExt | input | 1 | Slot format bit, 1 = extended |
| frmValid | input | 1 | Incoming identifier strobe |
| frmId | input | 29 | Incoming identifier; standard frames use bits [10:0] |
| frmExt | input | 1 | Incoming frame is extended |
| frmRemote | input | 1 | Incoming frame is a remote frame |
| hitValid | output | 1 | A slot accepted the previous cycle's frame |
| hitIdx | output | 4 | Accepting slot number, 0 when there is no hit |
| hitRemote | output | 1 | Remote flag of the accepted frame |

## Verification
A corrupted slot identifier, enable, direction or format bit shows up at the next frame aimed at that slot. The slot either misses the frame, or a different slot number appears one clock after the strobe. A wrong mask bit shows only on frames that differ from a slot identifier in exactly that bit, so the stimulus flips single bits of configured identifiers. A broken priority or fallback decision shows as the wrong slot number whenever two slots overlap, or when slot 15 and a lower slot both accept a frame.

// File: rtl/canAfPkg.sv
package canAfPkg;
  typedef enum logic [1:0] {
    TGT_OBJ      = 2'd0,
    TGT_STDMASK  = 2'd1,
    TGT_EXTMASK  = 2'd2,
    TGT_LASTMASK = 2'd3
  } cfgTarget_e;

  typedef struct packed {
    logic objWr;
    logic stdMaskWr;
    logic extMaskWr;
    logic lastMaskWr;
  } afStrobes_t;
endpackage

// File: rtl/canAfDatapath.sv
module canAfDatapath
  import canAfPkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  parameter int OBJ_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  afStrobes_t         strb,
  input  logic [OBJ_W-1:0]   cfgObj,
  input  logic [ID_W-1:0]    cfgId,
  input  logic               cfgValid,
  input  logic               cfgRx,
  input  logic               cfgExt,
  input  logic               frmValid,
  input  logic [ID_W-1:0]    frmId,
  input  logic               frmExt,
  output logic [NUM_OBJ-1:0] matchVec
);
  localparam int LAST = NUM_OBJ - 1;

  logic [ID_W-1:0]    objId [NUM_OBJ];
  logic [NUM_OBJ-1:0] objEn;
  logic [NUM_OBJ-1:0] objRx;
  logic [NUM_OBJ-1:0] objExt;
  logic [STD_W-1:0]   stdMask;
  logic [ID_W-1:0]    extMask;
  logic [ID_W-1:0]    lastMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdMask  <= '1;
      extMask  <= '1;
      lastMask <= '1;
      objEn    <= '0;
      objExt   <= '0;
      for (int i = 0; i < NUM_OBJ; i++) begin
        objId[i] <= '0;
        objRx[i] <= (i == LAST);
      end
    end else begin
      if (strb.stdMaskWr)  stdMask  <= cfgId[STD_W-1:0];
      if (strb.extMaskWr)  extMask  <= cfgId;
      if (strb.lastMaskWr) lastMask <= cfgId;
      for (int i = 0; i < NUM_OBJ; i++) begin
        if (strb.objWr && (int'(cfgObj) == i + 1)) begin
          objId[i]  <= cfgId;
          objEn[i]  <= cfgValid;
          objExt[i] <= cfgExt;
          objRx[i]  <= (i == LAST) ? 1'b1 : cfgRx;
        end
      end
    end
  end

  logic [ID_W-1:0] globalMask;
  assign globalMask = frmExt ? extMask : {{(ID_W-STD_W){1'b0}}, stdMask};

  for (genvar g = 0; g < NUM_OBJ; g++) begin : gCmp
    logic [ID_W-1:0] effMask;
    if (g == LAST) begin : gLast
      assign effMask = globalMask & lastMask;
    end else begin : gReg
      assign effMask = globalMask;
    end
    assign matchVec[g] = objEn[g] && objRx[g] && (objExt[g] == frmExt) &&
                         (((frmId ^ objId[g]) & effMask) == '0);
  end

  AST_FORMAT_GATE: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> ((matchVec & (frmExt ? ~objExt : objExt)) == '0)); // R5

  AST_LAST_RECEIVES: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.objWr && (int'(cfgObj) == NUM_OBJ)) |-> objRx[LAST]); // R8
endmodule

// File: rtl/canAfCtrl.sv
module canAfCtrl
  import canAfPkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int OBJ_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgTarget,
  input  logic [OBJ_W-1:0]   cfgObj,
  output afStrobes_t         strb,
  input  logic               frmValid,
  input  logic               frmRemote,
  input  logic [NUM_OBJ-1:0] matchVec,
  output logic               hitValid,
  output logic [OBJ_W-1:0]   hitIdx,
  output logic               hitRemote
);
  cfgTarget_e tgt;
  logic       objInRange;

  assign tgt        = cfgTarget_e'(cfgTarget);
  assign objInRange = (cfgObj != '0) && (int'(cfgObj) <= NUM_OBJ);

  always_comb begin
    strb            = '0;
    strb.objWr      = cfgWrEn && (tgt == TGT_OBJ) && objInRange;
    strb.stdMaskWr  = cfgWrEn && (tgt == TGT_STDMASK);
    strb.extMaskWr  = cfgWrEn && (tgt == TGT_EXTMASK);
    strb.lastMaskWr = cfgWrEn && (tgt == TGT_LASTMASK);
  end

  logic             found;
  logic [OBJ_W-1:0] selIdx;

  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int i = 0; i < NUM_OBJ - 1; i++) begin
      if (!found && matchVec[i]) begin
        found  = 1'b1;
        selIdx = OBJ_W'(i + 1);
      end
    end
    if (!found && matchVec[NUM_OBJ-1]) begin
      found  = 1'b1;
      selIdx = OBJ_W'(NUM_OBJ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitValid  <= 1'b0;
      hitIdx    <= '0;
      hitRemote <= 1'b0;
    end else begin
      hitValid  <= frmValid && found;
      hitIdx    <= (frmValid && found) ? selIdx : '0;
      hitRemote <= frmValid && found && frmRemote;
    end
  end

  AST_HIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $past(frmValid)); // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (hitIdx != '0) && (int'(hitIdx) <= NUM_OBJ)); // R11

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitIdx == '0) && !hitRemote); // R9

  AST_LAST_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && int'(hitIdx) == NUM_OBJ) |-> $past(matchVec[NUM_OBJ-2:0] == '0)); // R7
endmodule

// File: rtl/canAcceptFilter.sv
module canAcceptFilter
  import canAfPkg::*;
#(
  parameter int NUM_OBJ = 15,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  parameter int OBJ_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgTarget,
  input  logic [OBJ_W-1:0] cfgObj,
  input  logic [ID_W-1:0]  cfgId,
  input  logic             cfgValid,
  input  logic             cfgRx,
  input  logic             cfgExt,
  input  logic             frmValid,
  input  logic [ID_W-1:0]  frmId,
  input  logic             frmExt,
  input  logic             frmRemote,
  output logic             hitValid,
  output logic [OBJ_W-1:0] hitIdx,
  output logic             hitRemote
);
  afStrobes_t         strb;
  logic [NUM_OBJ-1:0] matchVec;

  canAfCtrl #(.NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTarget(cfgTarget),
    .cfgObj(cfgObj), .strb(strb), .frmValid(frmValid), .frmRemote(frmRemote),
    .matchVec(matchVec), .hitValid(hitValid), .hitIdx(hitIdx),
    .hitRemote(hitRemote)
  );

  canAfDatapath #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .STD_W(STD_W),
                  .OBJ_W(OBJ_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgObj(cfgObj), .cfgId(cfgId),
    .cfgValid(cfgValid), .cfgRx(cfgRx), .cfgExt(cfgExt),
    .frmValid(frmValid), .frmId(frmId), .frmExt(frmExt), .matchVec(matchVec)
  );
endmodule

// File: tb/canAcceptFilter_tb.sv
module canAcceptFilter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 15;

  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWrEn = 0;
  logic [1:0]  cfgTarget = 0;
  logic [3:0]  cfgObj = 0;
  logic [28:0] cfgId = 0;
  logic        cfgValid = 0, cfgRx = 0, cfgExt = 0;
  logic        frmValid = 0;
  logic [28:0] frmId = 0;
  logic        frmExt = 0, frmRemote = 0;
  logic        hitValid;
  logic [3:0]  hitIdx;
  logic        hitRemote;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  canAcceptFilter dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgTarget(cfgTarget),
    .cfgObj(cfgObj), .cfgId(cfgId), .cfgValid(cfgValid), .cfgRx(cfgRx),
    .cfgExt(cfgExt), .frmValid(frmValid), .frmId(frmId), .frmExt(frmExt),
    .frmRemote(frmRemote), .hitValid(hitValid), .hitIdx(hitIdx),
    .hitRemote(hitRemote)
  );

  // Behavioural reference model
  int mId [N];
  bit mEn [N];
  bit mRx [N];
  bit mExt [N];
  int mStd, mExtM, mLast;
  bit expV, expR;
  int expI;

  function automatic int modelPick(int id, bit ext);
    int msk;
    msk = ext ? mExtM : (mStd & 'h7FF);
    for (int i = 0; i < N - 1; i++)
      if (mEn[i] && mRx[i] && mExt[i] == ext && (((id ^ mId[i]) & msk) == 0))
        return i + 1;
    if (mEn[N-1] && mExt[N-1] == ext && (((id ^ mId[N-1]) & msk & mLast) == 0))
      return N;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mId[i] = 0; mEn[i] = 0; mRx[i] = 0; mExt[i] = 0;
      end
      mStd = 'h7FF; mExtM = 'h1FFFFFFF; mLast = 'h1FFFFFFF;
      expV = 0; expI = 0; expR = 0;
    end else begin
      int p;
      p = frmValid ? modelPick(int'(frmId), frmExt) : 0;
      expV = (p != 0);
      expI = p;
      expR = (p != 0) && frmRemote;
      if (cfgWrEn) begin
        case (cfgTarget)
          2'd0: if (cfgObj >= 1 && cfgObj <= N) begin
                  mId[cfgObj-1] = int'(cfgId); mEn[cfgObj-1] = cfgValid;
                  mRx[cfgObj-1] = cfgRx; mExt[cfgObj-1] = cfgExt;
                end
          2'd1: mStd = int'(cfgId) & 'h7FF;
          2'd2: mExtM = int'(cfgId);
          default: mLast = int'(cfgId);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (hitValid !== expV || int'(hitIdx) != expI || hitRemote !== expR) begin
        errors++;
        $display("FAIL %s model: got v=%0b idx=%0d rem=%0b expected v=%0b idx=%0d rem=%0b",
                 curReq, hitValid, hitIdx, hitRemote, expV, expI, expR);
      end
    end
  end

  task automatic check(string req, bit v, int idx, bit rem);
    checks++;
    if (hitValid !== v || int'(hitIdx) != idx || hitRemote !== rem) begin
      errors++;
      $display("FAIL %s: got v=%0b idx=%0d rem=%0b expected v=%0b idx=%0d rem=%0b",
               req, hitValid, hitIdx, hitRemote, v, idx, rem);
    end
  endtask

  task automatic wrCfg(int tgt, int obj, int id, bit v, bit rx, bit ext);
    @(negedge clk);
    cfgWrEn = 1; cfgTarget = 2'(tgt); cfgObj = 4'(obj); cfgId = 29'(id);
    cfgValid = v; cfgRx = rx; cfgExt = ext;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic sendFrame(int id, bit ext, bit rem);
    @(negedge clk);
    frmValid = 1; frmId = 29'(id); frmExt = ext; frmRemote = rem;
    @(negedge clk);
    frmValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0);
    rstN = 1;
    curReq = "R1";
    sendFrame('h000, 0, 0);
    check("R1", 0, 0, 0);
    sendFrame('h0, 1, 0);
    check("R1", 0, 0, 0);

    curReq = "R6";
    wrCfg(0, 3, 'h123, 1, 1, 0);
    wrCfg(0, 5, 'h123, 1, 1, 0);
    sendFrame('h123, 0, 0);
    check("R6", 1, 3, 0);
    @(negedge clk);
    check("R2", 0, 0, 0);

    curReq = "R5";
    sendFrame('h123, 1, 0);
    check("R5", 0, 0, 0);
    wrCfg(0, 2, 'h123, 1, 0, 0);
    sendFrame('h123, 0, 0);
    check("R5", 1, 3, 0);

    curReq = "R3";
    sendFrame('h12A, 0, 0);
    check("R3", 0, 0, 0);
    wrCfg(1, 0, 'h7F0, 0, 0, 0);
    sendFrame('h12A, 0, 0);
    check("R3", 1, 3, 0);
    wrCfg(1, 0, 'h7FF, 0, 0, 0);

    curReq = "R4";
    wrCfg(0, 7, 'h1ABCDEF0, 1, 1, 1);
    sendFrame('h1ABCDEF0, 1, 0);
    check("R4", 1, 7, 0);
    sendFrame('h1ABCDEF1, 1, 0);
    check("R4", 0, 0, 0);
    wrCfg(2, 0, 'h1FFFFFFE, 0, 0, 0);
    sendFrame('h1ABCDEF1, 1, 0);
    check("R4", 1, 7, 0);

    curReq = "R7";
    wrCfg(0, 15, 'h300, 1, 0, 0);
    wrCfg(3, 0, 'h700, 0, 0, 0);
    sendFrame('h3FF, 0, 0);
    check("R8", 1, 15, 0);
    sendFrame('h123, 0, 0);
    check("R7", 1, 3, 0);

    curReq = "R9";
    sendFrame('h123, 0, 1);
    check("R9", 1, 3, 1);
    sendFrame('h3AB, 0, 1);
    check("R9", 1, 15, 1);

    curReq = "R10";
    @(negedge clk);
    cfgWrEn = 1; cfgTarget = 0; cfgObj = 3; cfgId = 'h123;
    cfgValid = 0; cfgRx = 1; cfgExt = 0;
    frmValid = 1; frmId = 'h123; frmExt = 0; frmRemote = 0;
    @(negedge clk);
    cfgWrEn = 0; frmValid = 0;
    check("R10", 1, 3, 0);
    sendFrame('h123, 0, 0);
    check("R10", 1, 5, 0);

    curReq = "R11";
    wrCfg(0, 0, 'h555, 1, 1, 0);
    sendFrame('h555, 0, 0);
    check("R11", 0, 0, 0);

    curReq = "R6";
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        int t;
        t = $urandom_range(0, 3);
        if (t == 0)
          wrCfg(0, $urandom_range(1, 15), $urandom_range(0, 15) << 4,
                $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                $urandom_range(0, 1));
        else
          wrCfg(t, 0, int'($urandom) | int'($urandom), 0, 0, 0);
      end
      sendFrame(($urandom_range(0, 15) << 4) ^ (1 << $urandom_range(0, 12)),
                $urandom_range(0, 1), $urandom_range(0, 1));
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule